// File: doc/BRIEF.md
# Lazy Transactional Read/Write Set Tracker

This block follows one core's memory transaction using a lazy scheme. For every line of a 16-line direct-mapped cache it keeps a read bit, a write bit and the line tag. A transactional load sets the read bit of its line. A transactional store sets the write bit, and its data changes only in the local cache. When a request misses, the block asks the cache for a read-only fill and completes the request once the fill is acknowledged. The data array, memory, pipeline flush and register checkpoint are outside the block. They connect through simple request and acknowledge pins.

Conflicts are only found when some transaction commits. While its own transaction runs, the block watches the invalidations that other cores' commits put on the bus. An invalidation that matches a line in the local read set means atomicity is lost. The block then aborts: it pulses a single abort output, clears every bit and returns to idle, and software retries from the begin point. Evicting a written line also aborts the transaction. So does a request to a cache index that already holds a different tracked line.

At the end of a transaction with a non-empty write set, the block asks a central arbiter for the bus. It keeps the bus until every written line address has been broadcast, one per cycle, in ascending index order. No data is written back: the dirty lines stay in the cache until they are evicted later. A transaction with an empty write set commits at once without using the bus.

Top module: `txn_set_tracker`

## Requirements
- R1: After reset, in_txn, req_done, fill_req, abort, arb_req, inv_valid and commit_done are all low, and no line is tracked.
- R2: tx_begin while idle sets in_txn from the next cycle. tx_begin while a transaction is already open is ignored.
- R3: With a transaction open and no end request, a request with req_hit=1 raises req_done in the same cycle. A load sets the read bit of line index req_line[3:0] and records tag req_line[LINE_W-1:4]. A store sets only the write bit.
- R4: A request with req_hit=0 raises fill_req in the same cycle. fill_req stays high until fill_ack, and req_done is raised in the fill_ack cycle, after which the bit is set as in R3.
- R5: A request whose index already holds a tracked line (read or write bit set) with a different tag makes abort pulse in that cycle.
- R6: An eviction notice whose line matches a tracked line with its write bit set aborts the transaction. An eviction of a line that is only read leaves it tracked, so a later snoop of that line still aborts.
- R7: While running, waiting for a fill, or waiting for the arbiter, a snooped invalidation matching a line with its read bit set aborts the transaction. A snoop that matches a write-only line, or a line with a different tag, has no effect.
- R8: Abort, whether from cpu_abort or from R5, R6 or R7, is a one-cycle pulse. From the next cycle the block is idle with all bits cleared.
- R9: tx_end with a non-empty write set raises arb_req from the next cycle. From the cycle after arb_gnt, the block drives one inv_line per cycle, {tag, index}, for each written line in ascending index order, with arb_req held. commit_done is raised with the last address, and the block is idle with all bits clear afterwards.
- R10: tx_end with an empty write set raises commit_done in the same cycle, never raises arb_req, and the block is idle from the next cycle.
- R11: A matching snoop in the same cycle as tx_end, or in the same cycle as arb_gnt, makes the transaction abort instead of commit.
- R12: Once the bus is granted, snoops, evictions and cpu_abort have no effect until commit_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Open a transaction |
| tx_end | input | 1 | Request commit of the open transaction |
| cpu_abort | input | 1 | Abort requested by the core |
| req_valid | input | 1 | Transactional load/store request, held until req_done |
| req_write | input | 1 | 1 = store, 0 = load |
| req_hit | input | 1 | Line present in the cache |
| req_line | input | LINE_W | Line address of the request |
| fill_ack | input | 1 | Read-only fill complete |
| evict_valid | input | 1 | Cache evicts a line |
| evict_line | input | LINE_W | Evicted line address |
| snp_valid | input | 1 | Invalidation seen on the bus |
| snp_line | input | LINE_W | Snooped line address |
| arb_gnt | input | 1 | Arbiter grants the bus |
| in_txn | output | 1 | A transaction is open |
| req_done | output | 1 | Request completed |
| fill_req | output | 1 | Read-only fill request for req_line |
| abort | output | 1 | One-cycle abort pulse for flush and checkpoint restore |
| arb_req | output | 1 | Bus request, held through the broadcast |
| inv_valid | output | 1 | Invalidation broadcast valid |
| inv_line | output | LINE_W | Broadcast line address |
| commit_done | output | 1 | Commit completes this cycle |

## Verification
Two events can land in the same cycle: a snooped invalidation hitting the read set, and a commit step, either the end request or the arbiter's grant. Both races are provoked by driving a matching snoop together with tx_end, and again together with arb_gnt. In each case the expected result is an abort pulse with no commit_done and no broadcast. The reverse case is also driven: snoops, evictions and core aborts that arrive during a granted broadcast must not disturb the address sequence. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/txn_set_tracker.sv
module txn_set_tracker #(
  parameter int LINES  = 16,
  parameter int LINE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin,
  input  logic              tx_end,
  input  logic              cpu_abort,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_hit,
  input  logic [LINE_W-1:0] req_line,
  input  logic              fill_ack,
  input  logic              evict_valid,
  input  logic [LINE_W-1:0] evict_line,
  input  logic              snp_valid,
  input  logic [LINE_W-1:0] snp_line,
  input  logic              arb_gnt,
  output logic              in_txn,
  output logic              req_done,
  output logic              fill_req,
  output logic              abort,
  output logic              arb_req,
  output logic              inv_valid,
  output logic [LINE_W-1:0] inv_line,
  output logic              commit_done
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = LINE_W - IDX_W;

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_FILL, S_ARB, S_COMMIT} st_t;

  st_t              st;
  logic [LINES-1:0] rd_q, wr_q, pend_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [IDX_W-1:0] first_idx;

  wire [IDX_W-1:0] r_idx = req_line[IDX_W-1:0];
  wire [TAG_W-1:0] r_tag = req_line[LINE_W-1:IDX_W];
  wire [IDX_W-1:0] s_idx = snp_line[IDX_W-1:0];
  wire [IDX_W-1:0] e_idx = evict_line[IDX_W-1:0];

  wire tracking = (st == S_RUN) || (st == S_FILL) || (st == S_ARB);
  wire snp_hit  = snp_valid && rd_q[s_idx] && (tag_q[s_idx] == snp_line[LINE_W-1:IDX_W]);
  wire ev_hit   = evict_valid && wr_q[e_idx] && (tag_q[e_idx] == evict_line[LINE_W-1:IDX_W]);
  wire run_req  = (st == S_RUN) && !tx_end && req_valid;
  wire overflow = run_req && (rd_q[r_idx] || wr_q[r_idx]) && (tag_q[r_idx] != r_tag);
  wire last_inv = ((pend_q & (pend_q - LINES'(1))) == '0);

  assign abort     = tracking && (snp_hit || ev_hit || cpu_abort || overflow);
  assign in_txn    = (st != S_IDLE);
  assign req_done  = !abort && ((run_req && req_hit) || ((st == S_FILL) && fill_ack));
  assign fill_req  = !abort && ((run_req && !req_hit) || (st == S_FILL));
  assign arb_req   = (st == S_ARB) || (st == S_COMMIT);
  assign inv_valid = (st == S_COMMIT);
  assign inv_line  = {tag_q[first_idx], first_idx};
  assign commit_done = ((st == S_COMMIT) && last_inv) ||
                       ((st == S_RUN) && tx_end && !abort && (wr_q == '0));

  always_comb begin
    first_idx = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (pend_q[i]) first_idx = IDX_W'(i);
  end

  always_ff @(posedge clk)
    if (req_done) tag_q[r_idx] <= r_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rd_q   <= '0;
      wr_q   <= '0;
      pend_q <= '0;
    end else if (abort) begin
      st   <= S_IDLE;
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      if (req_done) begin
        if (req_write) wr_q[r_idx] <= 1'b1;
        else           rd_q[r_idx] <= 1'b1;
      end
      case (st)
        S_IDLE: if (tx_begin) st <= S_RUN;
        S_RUN: begin
          if (tx_end) begin
            if (wr_q == '0) begin
              st   <= S_IDLE;
              rd_q <= '0;
            end else st <= S_ARB;
          end else if (req_valid && !req_hit) st <= S_FILL;
        end
        S_FILL: if (fill_ack) st <= S_RUN;
        S_ARB: if (arb_gnt) begin
          st     <= S_COMMIT;
          pend_q <= wr_q;
        end
        S_COMMIT: begin
          pend_q <= pend_q & (pend_q - LINES'(1));
          if (last_inv) begin
            st   <= S_IDLE;
            rd_q <= '0;
            wr_q <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!in_txn && rd_q == '0 && wr_q == '0)); // R8
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort); // R8
  AST_ABORT_NOT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort && commit_done)); // R11
  AST_INV_UNDER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> arb_req); // R9
  AST_INV_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && $past(inv_valid)) |-> (inv_line[IDX_W-1:0] > $past(inv_line[IDX_W-1:0]))); // R9
endmodule

// File: tb/txn_set_tracker_test.sv
module txn_set_tracker_test;
  localparam int LW = 20;

  logic clk = 0, rst_n = 0;
  logic tx_begin = 0, tx_end = 0, cpu_abort = 0;
  logic req_valid = 0, req_write = 0, req_hit = 0;
  logic [LW-1:0] req_line = '0, evict_line = '0, snp_line = '0;
  logic fill_ack = 0, evict_valid = 0, snp_valid = 0, arb_gnt = 0;
  logic in_txn, req_done, fill_req, abort, arb_req, inv_valid, commit_done;
  logic [LW-1:0] inv_line;

  int tests = 0, fails = 0;
  bit finished = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  txn_set_tracker #(.LINES(16), .LINE_W(LW)) uut (
    .clk, .rst_n, .tx_begin, .tx_end, .cpu_abort, .req_valid, .req_write,
    .req_hit, .req_line, .fill_ack, .evict_valid, .evict_line, .snp_valid,
    .snp_line, .arb_gnt, .in_txn, .req_done, .fill_req, .abort, .arb_req,
    .inv_valid, .inv_line, .commit_done);

  int mst;
  bit mrd[16], mwr[16];
  int mtag[16];
  int pend[$];

  task automatic chk(string sig, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, sig, act, exp);
    end
  endtask

  function automatic void mclear();
    for (int i = 0; i < 16; i++) begin mrd[i] = 0; mwr[i] = 0; end
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mst = 0; mclear(); pend.delete();
    end else begin
      int ri, rt, si, ei;
      bit trk, shit, ehit, ovf, e_abort, runreq, e_done, e_fill, e_cd, anyw;
      ri = req_line % 16; rt = req_line / 16;
      si = snp_line % 16; ei = evict_line % 16;
      anyw = 0;
      for (int i = 0; i < 16; i++) if (mwr[i]) anyw = 1;
      trk    = (mst == 1 || mst == 2 || mst == 3);
      shit   = snp_valid && mrd[si] && mtag[si] == snp_line / 16;
      ehit   = evict_valid && mwr[ei] && mtag[ei] == evict_line / 16;
      runreq = (mst == 1) && !tx_end && req_valid;
      ovf    = runreq && (mrd[ri] || mwr[ri]) && mtag[ri] != rt;
      e_abort = trk && (shit || ehit || cpu_abort || ovf);
      e_done = !e_abort && ((runreq && req_hit) || (mst == 2 && fill_ack));
      e_fill = !e_abort && ((runreq && !req_hit) || mst == 2);
      e_cd   = (mst == 4 && pend.size() == 1) || (mst == 1 && tx_end && !e_abort && !anyw);
      chk("in_txn", in_txn, mst != 0);
      chk("req_done", req_done, e_done);
      chk("fill_req", fill_req, e_fill);
      chk("abort", abort, e_abort);
      chk("arb_req", arb_req, mst == 3 || mst == 4);
      chk("inv_valid", inv_valid, mst == 4);
      chk("commit_done", commit_done, e_cd);
      if (mst == 4) chk("inv_line", inv_line, mtag[pend[0]] * 16 + pend[0]);
      if (e_done) begin
        mtag[ri] = rt;
        if (req_write) mwr[ri] = 1; else mrd[ri] = 1;
      end
      if (e_abort) begin
        mst = 0; mclear();
      end else case (mst)
        0: if (tx_begin) mst = 1;
        1: if (tx_end) begin
             if (anyw) mst = 3; else begin mst = 0; mclear(); end
           end else if (req_valid && !req_hit) mst = 2;
        2: if (fill_ack) mst = 1;
        3: if (arb_gnt) begin
             for (int i = 0; i < 16; i++) if (mwr[i]) pend.push_back(i);
             mst = 4;
           end
        4: begin
             void'(pend.pop_front());
             if (pend.size() == 0) begin mst = 0; mclear(); end
           end
        default: mst = 0;
      endcase
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic begin_tx();
    tx_begin = 1; cyc(); tx_begin = 0;
  endtask

  task automatic hit(bit wr, int line);
    req_valid = 1; req_write = wr; req_hit = 1; req_line = LW'(line);
    cyc(); req_valid = 0; req_hit = 0;
  endtask

  task automatic miss(bit wr, int line, int wait_n);
    req_valid = 1; req_write = wr; req_hit = 0; req_line = LW'(line);
    cyc(wait_n); fill_ack = 1; cyc(); fill_ack = 0; req_valid = 0;
  endtask

  task automatic snoop(int line);
    snp_valid = 1; snp_line = LW'(line); cyc(); snp_valid = 0;
  endtask

  task automatic evict(int line);
    evict_valid = 1; evict_line = LW'(line); cyc(); evict_valid = 0;
  endtask

  task automatic commit_seq(int gap, int tail);
    tx_end = 1; cyc(); tx_end = 0; cyc(gap);
    arb_gnt = 1; cyc(); arb_gnt = 0; cyc(tail);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    #0;
    phase = "R1";
    chk("in_txn", in_txn, 0); chk("arb_req", arb_req, 0);
    chk("abort", abort, 0); chk("inv_valid", inv_valid, 0);
    cyc(2);

    phase = "R2"; begin_tx(); begin_tx(); cyc();
    phase = "R3"; hit(0, 'h013); hit(1, 'h037);
    phase = "R4"; miss(1, 'h025, 3);
    phase = "R9"; commit_seq(2, 5);

    phase = "R7"; begin_tx(); hit(0, 'h042); hit(1, 'h048);
    snoop('h142); snoop('h048); cyc(); snoop('h042); cyc(2);

    phase = "R6"; begin_tx(); hit(1, 'h051); evict('h151); evict('h051); cyc(2);
    begin_tx(); hit(0, 'h061); evict('h061); cyc(); snoop('h061); cyc(2);

    phase = "R5"; begin_tx(); hit(0, 'h071); hit(0, 'h171); cyc(2);

    phase = "R10"; begin_tx(); hit(0, 'h081); tx_end = 1; cyc(); tx_end = 0; cyc(3);

    phase = "R11"; begin_tx(); hit(0, 'h091); hit(1, 'h0A2);
    tx_end = 1; snp_valid = 1; snp_line = 'h091; cyc(); tx_end = 0; snp_valid = 0; cyc(2);
    begin_tx(); hit(0, 'h091); hit(1, 'h0A2); tx_end = 1; cyc(); tx_end = 0; cyc(2);
    arb_gnt = 1; snp_valid = 1; snp_line = 'h091; cyc(); arb_gnt = 0; snp_valid = 0; cyc(3);

    phase = "R12"; begin_tx(); hit(0, 'h0B3); hit(1, 'h0C4); hit(1, 'h0D0); hit(1, 'h0DF);
    tx_end = 1; cyc(); tx_end = 0; cyc();
    arb_gnt = 1; cyc(); arb_gnt = 0;
    snp_valid = 1; snp_line = 'h0B3; evict_valid = 1; evict_line = 'h0C4; cpu_abort = 1;
    cyc(2); snp_valid = 0; evict_valid = 0; cpu_abort = 0; cyc(4);

    phase = "R8"; begin_tx(); hit(0, 'h0E5); cpu_abort = 1; cyc(); cpu_abort = 0; cyc(2);
    phase = "R7"; begin_tx(); hit(0, 'h0F6);
    req_valid = 1; req_write = 0; req_hit = 0; req_line = 'h0F7; cyc(2);
    snoop('h0F6); req_valid = 0; cyc(3);

    phase = "R9"; begin_tx(); miss(1, 'h10F, 1); hit(1, 'h101); hit(0, 'h108);
    commit_seq(0, 4);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired in %s", phase);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule